// File: doc/BRIEF.md
# Output Amplitude Keying Controller

This block produces the 12-bit amplitude word that scales a synthesizer's output before it reaches the multiplier and the converter. A single active-high keying pin controls it. When the block is disabled the word stays at full scale. In manual keying the word switches at once between zero and a programmed scale factor. In automatic keying the word moves toward the target in fixed steps: a high key ramps it up to the scale factor, and a low key ramps it down to zero. A programmable step size sets the size of each move, and a programmable rate sets the time between moves.

The keying pin is asynchronous. It passes through a two-flop synchronizer before any logic uses it. A change on the pin during a ramp turns the ramp around from its current value. The word never jumps when this happens.

The controller is a state machine with seven states:
- BYPASS: the block is disabled.
- MAN_ON: manual mode, key high.
- MAN_OFF: manual mode, key low.
- RISE: automatic mode, key high, word not yet at the scale factor.
- AT_TOP: automatic mode, key high, word equal to the scale factor.
- FALL: automatic mode, key low, word not yet zero.
- AT_ZERO: automatic mode, key low, word equal to zero.

The next state is decided every cycle from the enable, the mode and the synchronized key. In automatic mode the current word also counts. The transitions are:
- Any state goes to BYPASS when enable is low.
- With enable high and manual mode, any state goes to MAN_ON or MAN_OFF according to the key.
- With enable high and automatic mode, a high key selects RISE, or AT_TOP once the word equals the scale factor.
- With enable high and automatic mode, a low key selects FALL, or AT_ZERO once the word is zero.

Top module: `amp_key_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the amplitude word is 4095 (all ones).
- R2: When `enable` is 0, the word is 4095 one clock after the sampling edge, whatever the key, mode or settings.
- R3: In manual mode (`enable`=1, `auto_ramp`=0), the word becomes `scale` when the synchronized key is 1 and becomes 0 when it is 0, one clock later.
- R4: A change on `key_in` first shows on `amp_out` after the third rising edge that follows it: two edges for the synchronizer and one for the output register.
- R5: In automatic mode with the synchronized key at 1, the word increases by `step` once every `rate`+1 cycles and stays unchanged on the other cycles.
- R6: In automatic mode with the synchronized key at 0, the word decreases by `step` on each rate tick.
- R7: A rising ramp stops exactly at `scale`, and a falling ramp stops exactly at 0. An overshoot is clamped, including a sum that would pass 4095.
- R8: A key reversal in the middle of a ramp continues from the current word in the new direction. The word never jumps.
- R9: The rate counter is held at zero outside automatic mode. With `rate`=0 a tick occurs on every cycle, so the first step after entering automatic mode comes `rate`+1 cycles after entry.
- R10: In automatic mode with the key at 1, a word above `scale` (for example after `scale` is lowered) drops to `scale` on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | 1 = amplitude scaling active, 0 = bypass at full scale |
| auto_ramp | input | 1 | 0 = manual keying, 1 = automatic ramping |
| scale | input | 12 | Programmed amplitude scale factor |
| step | input | 12 | Increment or decrement applied on each rate tick |
| rate | input | 16 | Number of idle cycles between ticks (interval = rate+1) |
| key_in | input | 1 | Asynchronous keying pin, active high |
| amp_out | output | 12 | Current amplitude multiplier word |

## Verification
The hardest case to reach from the ports is a key reversal that arrives while the word is partway between zero and the scale factor. The reversal must also fall at an arbitrary phase of the rate counter and beyond the synchronizer delay. The stimulus uses a small step and a short rate so the word spends many ticks mid-ramp. It then flips the key at several distances from the last tick, and also lowers the scale factor underneath a word that has already settled. A behavioural model that tracks the synchronizer stages and the tick counter as plain integers predicts the word on every cycle. Each of these moments is therefore checked cycle by cycle.

// File: rtl/amp_key_pkg.sv
package amp_key_pkg;
    typedef enum logic [2:0] {
        ST_BYPASS,
        ST_MAN_ON,
        ST_MAN_OFF,
        ST_RISE,
        ST_FALL,
        ST_AT_TOP,
        ST_AT_ZERO
    } ak_state_e;
endpackage

// File: rtl/amp_key_sync.sv
module amp_key_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/amp_key_ratetick.sv
module amp_key_ratetick #(
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_i,
    input  logic [RW-1:0] rate_i,
    output logic          tick_o
);
    logic [RW-1:0] cnt_q;

    assign tick_o = active_i && (cnt_q >= rate_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (!active_i) cnt_q <= '0;
        else if (tick_o)    cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    // R9
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && rate_i != '0) |=> (!tick_o || rate_i == '0));

    // R9
    idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (tick_o == (rate_i == '0 && active_i)));
endmodule

// File: rtl/amp_key_stepper.sv
module amp_key_stepper #(
    parameter int AW = 12
) (
    input  logic [AW-1:0] amp_i,
    input  logic [AW-1:0] step_i,
    input  logic [AW-1:0] limit_i,
    output logic [AW-1:0] up_o,
    output logic [AW-1:0] down_o
);
    logic [AW:0] sum;

    always_comb begin
        sum = {1'b0, amp_i} + {1'b0, step_i};
        if (sum >= {1'b0, limit_i}) up_o = limit_i;
        else                        up_o = sum[AW-1:0];
        if (amp_i <= step_i) down_o = '0;
        else                 down_o = amp_i - step_i;
    end
endmodule

// File: rtl/amp_key_ctrl.sv
module amp_key_ctrl
    import amp_key_pkg::*;
#(
    parameter int AW        = 12,
    parameter int RW        = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          auto_ramp,
    input  logic [AW-1:0] scale,
    input  logic [AW-1:0] step,
    input  logic [RW-1:0] rate,
    input  logic          key_in,
    output logic [AW-1:0] amp_out
);
    localparam logic [AW-1:0] FULL = {AW{1'b1}};

    ak_state_e     state_q, state_d;
    logic          key_s;
    logic          tick;
    logic          auto_on;
    logic [AW-1:0] amp_q, amp_d;
    logic [AW-1:0] up_val, down_val;

    assign auto_on = enable && auto_ramp;

    amp_key_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(key_in), .sync_o(key_s)
    );

    amp_key_ratetick #(.RW(RW)) u_tick (
        .clk(clk), .rst_n(rst_n), .active_i(auto_on), .rate_i(rate), .tick_o(tick)
    );

    amp_key_stepper #(.AW(AW)) u_step (
        .amp_i(amp_q), .step_i(step), .limit_i(scale),
        .up_o(up_val), .down_o(down_val)
    );

    // next-state decision
    always_comb begin
        if (!enable)        state_d = ST_BYPASS;
        else if (!auto_ramp) state_d = key_s ? ST_MAN_ON : ST_MAN_OFF;
        else if (key_s)     state_d = (amp_q == scale) ? ST_AT_TOP : ST_RISE;
        else                state_d = (amp_q == '0) ? ST_AT_ZERO : ST_FALL;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BYPASS;
        else        state_q <= state_d;
    end

    // output word
    always_comb begin
        amp_d = amp_q;
        unique case (state_d)
            ST_BYPASS:  amp_d = FULL;
            ST_MAN_ON:  amp_d = scale;
            ST_MAN_OFF: amp_d = '0;
            ST_RISE:    if (tick) amp_d = up_val;
            ST_FALL:    if (tick) amp_d = down_val;
            ST_AT_TOP:  amp_d = amp_q;
            ST_AT_ZERO: amp_d = amp_q;
            default:    amp_d = FULL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) amp_q <= FULL;
        else        amp_q <= amp_d;
    end

    assign amp_out = amp_q;

    // R2
    bypass_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (amp_out == FULL && state_q == ST_BYPASS));

    // R3
    manual_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !auto_ramp) |=> (amp_out == ($past(key_s) ? $past(scale) : '0)));

    // R5
    auto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_on && !tick) |=> $stable(amp_out));

    // R8
    rise_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_on && key_s) |=> (amp_out >= $past(amp_out) || amp_out == $past(scale)));

    // R6
    fall_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_on && !key_s) |=> (amp_out <= $past(amp_out)));

    // R7
    rise_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_on && key_s && amp_out <= scale) |=> (amp_out <= $past(scale)));
endmodule

// File: tb/amp_key_ctrl_tb.sv
module amp_key_ctrl_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        auto_ramp = 1'b0;
    logic [11:0] scale = '0;
    logic [11:0] step = '0;
    logic [15:0] rate = '0;
    logic        key_in = 1'b0;
    logic [11:0] amp_out;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string cur_req = "R1";

    // model state
    int m_amp = 4095;
    int m_k1 = 0, m_k2 = 0, m_cnt = 0;

    always #(CLK_P/2) clk = ~clk;

    amp_key_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .auto_ramp(auto_ramp),
        .scale(scale), .step(step), .rate(rate), .key_in(key_in), .amp_out(amp_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: amp_out act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_amp = 4095; m_k1 = 0; m_k2 = 0; m_cnt = 0;
        end else begin
            bit act, tk;
            act = enable && auto_ramp;
            tk  = act && (m_cnt >= int'(rate));
            if (!enable)         m_amp = 4095;
            else if (!auto_ramp) m_amp = m_k2 ? int'(scale) : 0;
            else if (tk) begin
                if (m_k2) m_amp = (m_amp + int'(step) >= int'(scale)) ? int'(scale) : m_amp + int'(step);
                else      m_amp = (m_amp <= int'(step)) ? 0 : m_amp - int'(step);
            end
            m_cnt = act ? (tk ? 0 : m_cnt + 1) : 0;
            m_k2 = m_k1;
            m_k1 = int'(key_in);
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) chk(cur_req, int'(amp_out), m_amp);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: act=expired exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cyc(3);
        chk("R1", int'(amp_out), 4095);
        rst_n = 1'b1;
        cyc(1);
        chk("R1", int'(amp_out), 4095);

        // R2: disabled, key and settings wiggling
        cur_req = "R2";
        scale = 12'd1000; step = 12'd5; rate = 16'd2;
        for (int i = 0; i < 12; i++) begin
            key_in = i[1]; auto_ramp = i[2];
            cyc(1);
        end
        chk("R2", int'(amp_out), 4095);

        // R3 / R4: manual keying with latency check
        cur_req = "R3"; auto_ramp = 1'b0; key_in = 1'b0; enable = 1'b1;
        cyc(5);
        chk("R3", int'(amp_out), 0);
        key_in = 1'b1;
        cyc(2);
        chk("R4", int'(amp_out), 0);
        cyc(1);
        chk("R4", int'(amp_out), 1000);
        key_in = 1'b0;
        cyc(3);
        chk("R3", int'(amp_out), 0);

        // R5 / R7 / R9: automatic rise with clamp
        cur_req = "R5"; auto_ramp = 1'b1; step = 12'd300; rate = 16'd3; key_in = 1'b1;
        cyc(30);
        chk("R7", int'(amp_out), 1000);

        // R6: automatic fall to zero
        cur_req = "R6"; key_in = 1'b0;
        cyc(30);
        chk("R7", int'(amp_out), 0);

        // R8: reversals mid-ramp at varying phases
        cur_req = "R8"; step = 12'd50; rate = 16'd1;
        key_in = 1'b1; cyc(15);
        key_in = 1'b0; cyc(6);
        key_in = 1'b1; cyc(9);
        key_in = 1'b0; cyc(3);
        key_in = 1'b1; cyc(40);
        chk("R7", int'(amp_out), 1000);

        // R10: scale lowered under a settled word
        cur_req = "R10"; scale = 12'd400;
        cyc(4);
        chk("R10", int'(amp_out), 400);

        // R7 / R9: rate 0, overflow clamp at full scale
        cur_req = "R9"; scale = 12'd4095; step = 12'd1000; rate = 16'd0;
        cyc(8);
        chk("R7", int'(amp_out), 4095);
        key_in = 1'b0; cyc(10);
        chk("R9", int'(amp_out), 0);

        // mixed pattern across modes
        cur_req = "R8"; scale = 12'd777; step = 12'd33; rate = 16'd2;
        for (int i = 0; i < 60; i++) begin
            key_in = ((i * 7) % 11) > 4;
            if (i == 40) auto_ramp = 1'b0;
            if (i == 48) auto_ramp = 1'b1;
            if (i == 52) enable = 1'b0;
            if (i == 55) enable = 1'b1;
            cyc(1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule